// File: doc/BRIEF.md
# Priority-Deferred Issue Unit

This unit stands between decode and the one functional-unit issue port of an in-order, single-issue core. Each decoded instruction carries a priority bit. High-priority work (anything that can lead to a cache miss, plus its producers) issues straight away with architectural operands. Low-priority work never waits at decode. Its operands are renamed and it is parked in a circular buffer. It issues later, in program order, in cycles where the core would otherwise sit idle on a data-cache miss, or when a flush command drains the buffer, for example at loop exit.

Renaming gives every buffer slot three private rename registers: one for the result and one copy register for each source. A source produced by a still-buffered instruction reads that producer's result register. Any other source is first copied out of the architectural file into the slot's copy register by a move, and the move goes out on the high-priority path. While a miss is outstanding, the oldest buffered entry is held back if it reads the register whose load missed.

Top module: `prio_defer_issue`

## Requirements
- R1: With no miss outstanding, no flush in progress and a buffer that is not full, a decoded instruction with priority bit 1 issues in the same cycle with issHigh=1, issMove=0, all operand rename flags 0 and its architectural register numbers, and decTaken=1.
- R2: A decoded instruction with priority bit 0 whose sources need no move is taken (decTaken=1) without issuing in that cycle and is written into the buffer.
- R3: Slot s owns rename registers 3s (result), 3s+1 (copy of source A) and 3s+2 (copy of source B). Buffer slots are allocated 0,1,2,… with wrap. A buffered instruction issues with issDstRen=1 and issDst=3s. A source whose latest producer is still buffered in slot p reads rename register 3p.
- R4: A source with no buffered producer needs a move first. The move is issValid=1, issHigh=1, issMove=1, destination rename 3s+1 (source A) or 3s+2 (source B), srcA set to the architectural register, srcB zero. Source A is moved before source B, identical sources need one move, and decode is not taken during a move cycle.
- R5: A mapping to a buffered producer is dropped when that producer issues, or when a high-priority instruction writing the same architectural register issues. Later readers of that register then get a move.
- R6: While a miss is outstanding, the oldest buffered entry issues (issHigh=0) each cycle, in program order. No high-priority instruction or move issues during that time.
- R7: While a miss is outstanding, the oldest entry does not issue if either of its architectural source registers equals the missing register, and nothing younger passes it.
- R8: When the buffer is full and decode presents an instruction, the oldest entry issues first and decode is not taken in that cycle.
- R9: A flush request drains every buffered entry, one per cycle, starting in the cycle of the request. Decode is not taken while the flush runs. flushDone is 1 for exactly the one cycle in which the buffer is empty, with no issue in that cycle; on an empty buffer, that is the cycle of the request.
- R10: After reset nothing issues, decode is not taken without a valid instruction, and flushDone is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode offers an instruction; held until taken |
| decPrio | input | 1 | 1 = high priority, 0 = low priority |
| decDst | input | AW | Architectural destination register |
| decSrcA | input | AW | Architectural source A |
| decSrcB | input | AW | Architectural source B |
| missValid | input | 1 | A data-cache miss is outstanding |
| missReg | input | AW | Destination register of the missing load |
| flushReq | input | 1 | Drain all buffered low-priority entries |
| decTaken | output | 1 | Decode instruction accepted this cycle |
| issValid | output | 1 | An operation issues this cycle |
| issHigh | output | 1 | 1 = high-priority path (incl. moves), 0 = buffered entry |
| issMove | output | 1 | Issued operation is a copy into a rename register |
| issDstRen | output | 1 | issDst names a rename register |
| issDst | output | IDX_W | Destination register index |
| issSrcARen | output | 1 | issSrcA names a rename register |
| issSrcA | output | IDX_W | Source A index |
| issSrcBRen | output | 1 | issSrcB names a rename register |
| issSrcB | output | IDX_W | Source B index |
| flushDone | output | 1 | One-cycle pulse: flush finished, buffer empty |

## Verification
The bench runs a four-slot, eight-register build. It sweeps every source pair through the high path. After that comes one program-order scenario whose rename indices are worked out by hand from the slot formula. The scenario targets a source that reads a buffered producer (a design that moved it anyway would waste a cycle and read a stale value). It also targets a producer that has already issued and a register rewritten by high-priority work: a design that kept those mappings would hand out a rename register that is about to be reused. It checks identical sources, where a second move is one cycle too many. A head entry that reads the missing register must block without being bypassed. Finally it covers a full buffer with decode waiting, a flush behind a pending instruction, and a flush on an empty buffer, where a late or stretched flushDone would show.

// File: rtl/defer_issue_pkg.sv
package defer_issue_pkg;

  // Per-cycle decisions handed from the control to the datapath.
  typedef struct packed {
    logic popHead;   // issue oldest buffered entry
    logic passHigh;  // issue decode instruction on the high path
    logic moveA;     // issue copy of source A into slot copy register
    logic moveB;     // issue copy of source B into slot copy register
    logic push;      // write decode instruction into the buffer
  } strobe_t;

endpackage

// File: rtl/defer_issue_dp.sv
module defer_issue_dp
  import defer_issue_pkg::*;
#(
  parameter int DEPTH     = 100,
  parameter int ARCH_REGS = 16,
  parameter int IDX_W     = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [$clog2(ARCH_REGS)-1:0] decDst,
  input  logic [$clog2(ARCH_REGS)-1:0] decSrcA,
  input  logic [$clog2(ARCH_REGS)-1:0] decSrcB,
  input  logic                         missValid,
  input  logic [$clog2(ARCH_REGS)-1:0] missReg,
  output logic                         bufEmpty,
  output logic                         bufFull,
  output logic                         headBlocked,
  output logic                         mapHitA,
  output logic                         mapHitB,
  output logic                         sameSrc,
  output logic                         issValid,
  output logic                         issHigh,
  output logic                         issMove,
  output logic                         issDstRen,
  output logic [IDX_W-1:0]             issDst,
  output logic                         issSrcARen,
  output logic [IDX_W-1:0]             issSrcA,
  output logic                         issSrcBRen,
  output logic [IDX_W-1:0]             issSrcB
);

  localparam int AW = $clog2(ARCH_REGS);
  localparam int SW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [IDX_W-1:0] aIdx;
    logic [IDX_W-1:0] bIdx;
    logic [AW-1:0]    archA;
    logic [AW-1:0]    archB;
    logic [AW-1:0]    archDst;
  } entry_t;

  entry_t        slots [DEPTH];
  entry_t        headEnt;
  entry_t        newEnt;
  logic [SW-1:0] headPtr;
  logic [SW-1:0] tailPtr;
  logic [CW-1:0] fill;
  logic          mapValid [ARCH_REGS];
  logic [SW-1:0] mapTag   [ARCH_REGS];

  function automatic logic [IDX_W-1:0] renIdx(input logic [SW-1:0] s, input logic [1:0] k);
    return IDX_W'(3 * int'(s)) + IDX_W'(k);
  endfunction

  function automatic logic [SW-1:0] nextPtr(input logic [SW-1:0] p);
    return (p == SW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headEnt     = slots[headPtr];
  assign bufEmpty    = (fill == '0);
  assign bufFull     = (fill == CW'(DEPTH));
  assign mapHitA     = mapValid[decSrcA];
  assign mapHitB     = mapValid[decSrcB];
  assign sameSrc     = (decSrcA == decSrcB);
  assign headBlocked = missValid &&
                       (headEnt.archA == missReg || headEnt.archB == missReg);

  // Renamed form of the decode instruction, written on push.
  always_comb begin
    newEnt.archA   = decSrcA;
    newEnt.archB   = decSrcB;
    newEnt.archDst = decDst;
    newEnt.aIdx    = mapHitA ? renIdx(mapTag[decSrcA], 2'd0) : renIdx(tailPtr, 2'd1);
    if (mapHitB)      newEnt.bIdx = renIdx(mapTag[decSrcB], 2'd0);
    else if (sameSrc) newEnt.bIdx = renIdx(tailPtr, 2'd1);
    else              newEnt.bIdx = renIdx(tailPtr, 2'd2);
  end

  // Issue port selection.
  always_comb begin
    issValid   = 1'b0;
    issHigh    = 1'b0;
    issMove    = 1'b0;
    issDstRen  = 1'b0;
    issDst     = '0;
    issSrcARen = 1'b0;
    issSrcA    = '0;
    issSrcBRen = 1'b0;
    issSrcB    = '0;
    if (strb.popHead) begin
      issValid   = 1'b1;
      issDstRen  = 1'b1;
      issDst     = renIdx(headPtr, 2'd0);
      issSrcARen = 1'b1;
      issSrcA    = headEnt.aIdx;
      issSrcBRen = 1'b1;
      issSrcB    = headEnt.bIdx;
    end else if (strb.moveA || strb.moveB) begin
      issValid  = 1'b1;
      issHigh   = 1'b1;
      issMove   = 1'b1;
      issDstRen = 1'b1;
      issDst    = renIdx(tailPtr, strb.moveA ? 2'd1 : 2'd2);
      issSrcA   = IDX_W'(strb.moveA ? decSrcA : decSrcB);
    end else if (strb.passHigh) begin
      issValid = 1'b1;
      issHigh  = 1'b1;
      issDst   = IDX_W'(decDst);
      issSrcA  = IDX_W'(decSrcA);
      issSrcB  = IDX_W'(decSrcB);
    end
  end

  // Pointers, occupancy and rename table.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      fill    <= '0;
      for (int r = 0; r < ARCH_REGS; r++) begin
        mapValid[r] <= 1'b0;
        mapTag[r]   <= '0;
      end
    end else begin
      fill <= fill + CW'(strb.push) - CW'(strb.popHead);
      if (strb.popHead) begin
        headPtr <= nextPtr(headPtr);
        if (mapValid[headEnt.archDst] && mapTag[headEnt.archDst] == headPtr)
          mapValid[headEnt.archDst] <= 1'b0;
      end
      if (strb.passHigh) mapValid[decDst] <= 1'b0;
      if (strb.push) begin
        tailPtr         <= nextPtr(tailPtr);
        mapValid[decDst] <= 1'b1;
        mapTag[decDst]   <= tailPtr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) slots[tailPtr] <= newEnt;
  end

endmodule

// File: rtl/defer_issue_ctrl.sv
module defer_issue_ctrl
  import defer_issue_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    decValid,
  input  logic    decPrio,
  input  logic    missValid,
  input  logic    flushReq,
  input  logic    bufEmpty,
  input  logic    bufFull,
  input  logic    headBlocked,
  input  logic    mapHitA,
  input  logic    mapHitB,
  input  logic    sameSrc,
  output strobe_t strb,
  output logic    decTaken,
  output logic    flushDone
);

  logic flushing;
  logic movedA;
  logic movedB;
  logic flushAct;
  logic needA;
  logic needB;
  logic headGo;

  assign flushAct = flushing || flushReq;
  assign needA    = !mapHitA && !movedA;
  assign needB    = !mapHitB && !sameSrc && !movedB;
  assign headGo   = !bufEmpty && !headBlocked &&
                    (flushAct || missValid || (bufFull && decValid));

  always_comb begin
    strb         = '0;
    strb.popHead = headGo;
    if (!flushAct && decValid) begin
      if (decPrio) begin
        strb.passHigh = !headGo && !missValid;
      end else if (!bufFull) begin
        if (needA || needB) begin
          if (!headGo && !missValid) begin
            strb.moveA = needA;
            strb.moveB = !needA;
          end
        end else begin
          strb.push = 1'b1;
        end
      end
    end
  end

  assign decTaken  = strb.passHigh || strb.push;
  assign flushDone = flushAct && bufEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushing <= 1'b0;
      movedA   <= 1'b0;
      movedB   <= 1'b0;
    end else begin
      flushing <= flushAct && !bufEmpty;
      movedA   <= strb.push ? 1'b0 : (movedA || strb.moveA);
      movedB   <= strb.push ? 1'b0 : (movedB || strb.moveB);
    end
  end

endmodule

// File: rtl/prio_defer_issue.sv
module prio_defer_issue
  import defer_issue_pkg::*;
#(
  parameter  int DEPTH     = 100,
  parameter  int ARCH_REGS = 16,
  localparam int AW        = $clog2(ARCH_REGS),
  localparam int IDX_W     = ($clog2(3 * DEPTH) > AW) ? $clog2(3 * DEPTH) : AW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic             decPrio,
  input  logic [AW-1:0]    decDst,
  input  logic [AW-1:0]    decSrcA,
  input  logic [AW-1:0]    decSrcB,
  input  logic             missValid,
  input  logic [AW-1:0]    missReg,
  input  logic             flushReq,
  output logic             decTaken,
  output logic             issValid,
  output logic             issHigh,
  output logic             issMove,
  output logic             issDstRen,
  output logic [IDX_W-1:0] issDst,
  output logic             issSrcARen,
  output logic [IDX_W-1:0] issSrcA,
  output logic             issSrcBRen,
  output logic [IDX_W-1:0] issSrcB,
  output logic             flushDone
);

  strobe_t strb;
  logic    bufEmpty;
  logic    bufFull;
  logic    headBlocked;
  logic    mapHitA;
  logic    mapHitB;
  logic    sameSrc;

  defer_issue_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .decValid    (decValid),
    .decPrio     (decPrio),
    .missValid   (missValid),
    .flushReq    (flushReq),
    .bufEmpty    (bufEmpty),
    .bufFull     (bufFull),
    .headBlocked (headBlocked),
    .mapHitA     (mapHitA),
    .mapHitB     (mapHitB),
    .sameSrc     (sameSrc),
    .strb        (strb),
    .decTaken    (decTaken),
    .flushDone   (flushDone)
  );

  defer_issue_dp #(
    .DEPTH     (DEPTH),
    .ARCH_REGS (ARCH_REGS),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .decDst      (decDst),
    .decSrcA     (decSrcA),
    .decSrcB     (decSrcB),
    .missValid   (missValid),
    .missReg     (missReg),
    .bufEmpty    (bufEmpty),
    .bufFull     (bufFull),
    .headBlocked (headBlocked),
    .mapHitA     (mapHitA),
    .mapHitB     (mapHitB),
    .sameSrc     (sameSrc),
    .issValid    (issValid),
    .issHigh     (issHigh),
    .issMove     (issMove),
    .issDstRen   (issDstRen),
    .issDst      (issDst),
    .issSrcARen  (issSrcARen),
    .issSrcA     (issSrcA),
    .issSrcBRen  (issSrcBRen),
    .issSrcB     (issSrcB)
  );

endmodule

// File: rtl/defer_issue_chk.sv
module defer_issue_chk (
  input logic clk,
  input logic rstN,
  input logic decPrio,
  input logic decTaken,
  input logic missValid,
  input logic flushReq,
  input logic issValid,
  input logic issHigh,
  input logic issMove,
  input logic flushDone
);

  AST_HIGH_TAKEN_ISSUES: assert property (@(posedge clk) disable iff (!rstN)
    decTaken && decPrio |-> issValid && issHigh && !issMove); // R1

  AST_LOW_TAKEN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    decTaken && !decPrio |-> !(issValid && issHigh)); // R2

  AST_MOVE_HOLDS_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    issMove |-> issValid && issHigh && !decTaken); // R4

  AST_NO_HIGH_IN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    issValid && issHigh |-> !missValid); // R6

  AST_FLUSH_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |-> !issValid && !decTaken); // R9

  AST_FLUSH_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> (!flushDone || flushReq)); // R9

endmodule

bind prio_defer_issue defer_issue_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .decPrio   (decPrio),
  .decTaken  (decTaken),
  .missValid (missValid),
  .flushReq  (flushReq),
  .issValid  (issValid),
  .issHigh   (issHigh),
  .issMove   (issMove),
  .flushDone (flushDone)
);

// File: tb/tb_prio_defer_issue.sv
module tb_prio_defer_issue;

  localparam int DP = 4;
  localparam int NR = 8;
  localparam int AW = $clog2(NR);
  localparam int IW = ($clog2(3 * DP) > AW) ? $clog2(3 * DP) : AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          decValid = 1'b0;
  logic          decPrio = 1'b0;
  logic [AW-1:0] decDst = '0;
  logic [AW-1:0] decSrcA = '0;
  logic [AW-1:0] decSrcB = '0;
  logic          missValid = 1'b0;
  logic [AW-1:0] missReg = '0;
  logic          flushReq = 1'b0;
  logic          decTaken;
  logic          issValid;
  logic          issHigh;
  logic          issMove;
  logic          issDstRen;
  logic [IW-1:0] issDst;
  logic          issSrcARen;
  logic [IW-1:0] issSrcA;
  logic          issSrcBRen;
  logic [IW-1:0] issSrcB;
  logic          flushDone;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  prio_defer_issue #(.DEPTH(DP), .ARCH_REGS(NR)) dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decPrio(decPrio),
    .decDst(decDst), .decSrcA(decSrcA), .decSrcB(decSrcB),
    .missValid(missValid), .missReg(missReg), .flushReq(flushReq),
    .decTaken(decTaken), .issValid(issValid), .issHigh(issHigh), .issMove(issMove),
    .issDstRen(issDstRen), .issDst(issDst), .issSrcARen(issSrcARen), .issSrcA(issSrcA),
    .issSrcBRen(issSrcBRen), .issSrcB(issSrcB), .flushDone(flushDone)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int packIss(input int v, h, m, dr, d, ar, a, br, b);
    return (v << (3*IW+4)) | (h << (3*IW+3)) | (m << (3*IW+2)) | (dr << (3*IW+1)) |
           (d << (2*IW+2)) | (ar << (2*IW+1)) | (a << (IW+1)) | (br << IW) | b;
  endfunction

  task automatic chkIss(input string tag, input int v, h, m, dr, d, ar, a, br, b);
    chk(tag, packIss(int'(issValid), int'(issHigh), int'(issMove), int'(issDstRen), int'(issDst),
                     int'(issSrcARen), int'(issSrcA), int'(issSrcBRen), int'(issSrcB)),
        packIss(v, h, m, dr, d, ar, a, br, b));
  endtask

  // Apply inputs at the falling edge, then let combinational outputs settle.
  task automatic cyc(input logic v, p, input int d, a, b, input logic mv, input int mr, input logic fr);
    @(negedge clk);
    decValid = v; decPrio = p;
    decDst = AW'(d); decSrcA = AW'(a); decSrcB = AW'(b);
    missValid = mv; missReg = AW'(mr); flushReq = fr;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R10 reset state
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chkIss("R10 idle issue", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 taken", int'(decTaken), 0);
    chk("R10 flushDone", int'(flushDone), 0);

    // R1 sweep of every source pair on the high path
    for (int a = 0; a < NR; a++) begin
      for (int b = 0; b < NR; b++) begin
        cyc(1, 1, (a + b) % NR, a, b, 0, 0, 0);
        chkIss("R1 high pass", 1, 1, 0, 0, (a + b) % NR, 0, a, 0, b);
        chk("R1 taken", int'(decTaken), 1);
      end
    end

    // R4 low d5 a1 b2 into slot0: move A -> 1, move B -> 2, then R2 push
    cyc(1, 0, 5, 1, 2, 0, 0, 0);
    chkIss("R4 move A", 1, 1, 1, 1, 1, 0, 1, 0, 0);
    chk("R4 held", int'(decTaken), 0);
    cyc(1, 0, 5, 1, 2, 0, 0, 0);
    chkIss("R4 move B", 1, 1, 1, 1, 2, 0, 2, 0, 0);
    cyc(1, 0, 5, 1, 2, 0, 0, 0);
    chkIss("R2 push no issue", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 taken", int'(decTaken), 1);

    // R3 low d6 a5 b5 reads buffered producer slot0 -> no move, slot1
    cyc(1, 0, 6, 5, 5, 0, 0, 0);
    chkIss("R3 mapped no move", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 taken", int'(decTaken), 1);

    // R4 low d7 a4 b6: move A into 3*2+1=7, B mapped to slot1, slot2
    cyc(1, 0, 7, 4, 6, 0, 0, 0);
    chkIss("R4 single move", 1, 1, 1, 1, 7, 0, 4, 0, 0);
    cyc(1, 0, 7, 4, 6, 0, 0, 0);
    chk("R4 taken after move", int'(decTaken), 1);

    // R6 miss on r4 with a high instruction waiting
    cyc(1, 1, 2, 0, 0, 1, 4, 0);
    chkIss("R6 head slot0", 1, 0, 0, 1, 0, 1, 1, 1, 2);
    chk("R6 high held", int'(decTaken), 0);
    cyc(1, 1, 2, 0, 0, 1, 4, 0);
    chkIss("R6 head slot1", 1, 0, 0, 1, 3, 1, 0, 1, 0);
    // R7 slot2 reads r4, the missing register
    cyc(1, 1, 2, 0, 0, 1, 4, 0);
    chkIss("R7 blocked head", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 high still held", int'(decTaken), 0);
    cyc(1, 1, 2, 0, 0, 0, 0, 0);
    chkIss("R1 high after miss", 1, 1, 0, 0, 2, 0, 0, 0, 0);

    // R5 producer of r5 issued: reader needs a move into 3*3+1=10
    cyc(1, 0, 1, 5, 7, 0, 0, 0);
    chkIss("R5 issued producer move", 1, 1, 1, 1, 10, 0, 5, 0, 0);
    cyc(1, 0, 1, 5, 7, 0, 0, 0);
    chk("R5 push slot3", int'(decTaken), 1);

    // R5 high writes r7, dropping its mapping to slot2
    cyc(1, 1, 7, 0, 0, 0, 0, 0);
    chkIss("R1 high d7", 1, 1, 0, 0, 7, 0, 0, 0, 0);
    cyc(1, 0, 0, 7, 7, 0, 0, 0);
    chkIss("R5 rewritten reg move", 1, 1, 1, 1, 1, 0, 7, 0, 0);
    cyc(1, 0, 0, 7, 7, 0, 0, 0);
    chk("R4 identical sources one move", int'(decTaken), 1);

    // fill: low d2 a1 b1 reads slot3 -> slot1, buffer full
    cyc(1, 0, 2, 1, 1, 0, 0, 0);
    chk("R3 fill taken", int'(decTaken), 1);

    // R8 full buffer with high waiting: head slot2 goes first
    cyc(1, 1, 4, 0, 0, 0, 0, 0);
    chkIss("R8 forced head", 1, 0, 0, 1, 6, 1, 7, 1, 3);
    chk("R8 decode held", int'(decTaken), 0);
    cyc(1, 1, 4, 0, 0, 0, 0, 0);
    chkIss("R8 high next", 1, 1, 0, 0, 4, 0, 0, 0, 0);

    // R9 flush with a high instruction waiting
    cyc(1, 1, 5, 0, 0, 0, 0, 1);
    chkIss("R9 drain slot3", 1, 0, 0, 1, 9, 1, 10, 1, 6);
    chk("R9 decode held", int'(decTaken), 0);
    cyc(1, 1, 5, 0, 0, 0, 0, 0);
    chkIss("R9 drain slot0", 1, 0, 0, 1, 0, 1, 1, 1, 1);
    cyc(1, 1, 5, 0, 0, 0, 0, 0);
    chkIss("R9 drain slot1", 1, 0, 0, 1, 3, 1, 9, 1, 9);
    chk("R9 not done yet", int'(flushDone), 0);
    cyc(1, 1, 5, 0, 0, 0, 0, 0);
    chk("R9 done pulse", int'(flushDone), 1);
    chkIss("R9 idle on done", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 5, 0, 0, 0, 0, 0);
    chk("R9 pulse ends", int'(flushDone), 0);
    chkIss("R9 high resumes", 1, 1, 0, 0, 5, 0, 0, 0, 0);

    // R9 flush on an empty buffer
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 empty flush done", int'(flushDone), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 empty pulse ends", int'(flushDone), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule